// File: doc/BRIEF.md
# USB 1.1 Host Frame Control and Interrupt Registers

This block is the register and timing core of a USB 1.1 host controller. Software reaches five registers through a single-cycle write strobe with a register select and a registered read path. The registers are a command word, a status word, an interrupt enable mask, an 11-bit frame counter and a frame list base pointer. Setting the run bit starts a frame timer that produces one tick every `FRAME_CYC` clock cycles, which is 1 ms at the target clock. Each tick advances the frame counter, and the schedule fetch address is derived from the counter and the base pointer.

The schedule walker is not part of this block. It reports two kinds of per-frame event: a completion request and a short-packet notice. These events gather during a frame and become visible only at the next tick. They are latched there into two hidden cause bits, which show up together as one status flag. Each hidden cause has its own enable. Error events, host faults and a resume request from a suspended bus update the status word directly. A single registered level interrupt output summarises the status word and the hidden causes.

Top module: `usbh_frame_ctl`

## Requirements
- R1: After reset the registers read as follows: command 0x00, status 0x20 (only halted set), enable 0x0, frame 0, base 0. `irq`, `frame_tick` and `bus_reset` are low.
- R2: Writing command bit0 (run) as 1 while it is 0 clears status bit5 (halted) and pulses `frame_tick` on the following cycle. After that, `frame_tick` pulses every `FRAME_CYC` cycles.
- R3: Writing command bit0 as 0 sets status bit5 on the next cycle, and no further `frame_tick` pulse occurs.
- R4: Each `frame_tick` advances the frame register by one, modulo 2048. The value 0x7FF is followed by 0.
- R5: A write to the frame register (select 3) takes effect only while halted, and only bits 10:0 are kept. While running the write is ignored.
- R6: A write to the base register (select 4) clears bits 11:0. `sched_addr` equals base + 4 × frame[9:0].
- R7: Completion (`ev_ioc`) and short-packet (`ev_short`) events seen during a frame are moved at the next tick into hidden causes 0 and 1, and status bit0 is set. A tick with no events pending leaves status bit0 unchanged.
- R8: Writing 1 to status bits 1 to 4 clears them. Writing 1 to bit0 clears bit0 and both hidden causes. Bit5 ignores status writes.
- R9: `irq` is high one cycle after any of these holds: hidden cause 0 with enable bit2, hidden cause 1 with enable bit3, status bit1 (USB error) with enable bit0, status bit2 (resume) with enable bit1, status bit3 (host error) or status bit4 (process error). The last two need no enable.
- R10: A `resume_req` pulse while command bit3 (suspend) is set sets command bit4 (force resume) and status bit2. While bit3 is clear the pulse is ignored.
- R11: Writing command bit1 (controller reset) returns every register to its R1 value and stops the frame timer.
- R12: Each command write with bit2 (global reset) set drives `bus_reset` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 command, 1 status, 2 enable, 3 frame, 4 base |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Selected register, registered |
| ev_ioc | input | 1 | Completion-interrupt request from the schedule walker |
| ev_short | input | 1 | Short-packet notice from the schedule walker |
| ev_usb_err | input | 1 | Transaction error event |
| ev_host_err | input | 1 | Host system error event |
| ev_proc_err | input | 1 | Process error event |
| resume_req | input | 1 | Resume signalling seen on a suspended bus |
| frame_tick | output | 1 | One-cycle pulse per frame boundary |
| sched_addr | output | 32 | Schedule entry address for the current frame |
| bus_reset | output | 1 | One-cycle reset pulse to all ports |
| irq | output | 1 | Level interrupt |

## Verification
The assertions rely on a few input properties. Event inputs are level samples taken once per clock. `FRAME_CYC` is at least two, so two ticks can never fall on adjacent cycles. A write to the frame register can only coincide with a tick if software writes while running, and the frame-step check excludes the cycle of a controller reset. The stimulus keeps to these properties. Every event pulse lasts one cycle and is placed just after an observed tick, so that it lands well inside a frame. Each register access is a separate one-cycle strobe driven between clock edges.

// File: rtl/usbh_ctl_pkg.sv
package usbh_ctl_pkg;
  typedef enum logic [2:0] {
    SEL_CMD  = 3'd0,
    SEL_STS  = 3'd1,
    SEL_IEN  = 3'd2,
    SEL_FRM  = 3'd3,
    SEL_BASE = 3'd4
  } reg_sel_e;

  // command bits
  localparam int C_RUN   = 0;
  localparam int C_HCRST = 1;
  localparam int C_GRST  = 2;
  localparam int C_SUSP  = 3;
  localparam int C_FRES  = 4;
  localparam int CMD_W   = 5;

  // status bits
  localparam int S_INT  = 0;
  localparam int S_ERR  = 1;
  localparam int S_RES  = 2;
  localparam int S_HSE  = 3;
  localparam int S_PERR = 4;
  localparam int S_HALT = 5;
  localparam int STS_W  = 6;

  // enable bits
  localparam int E_ERR = 0;
  localparam int E_RES = 1;
  localparam int E_IOC = 2;
  localparam int E_SPD = 3;
  localparam int IEN_W = 4;
endpackage

// File: rtl/usbh_frame_timer.sv
module usbh_frame_timer #(
  parameter int FRAME_CYC = 12000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic start,
  input  logic run,
  output logic tick_run,
  output logic tick_halt
);
  localparam int CNT_W = (FRAME_CYC > 2) ? $clog2(FRAME_CYC) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(FRAME_CYC - 1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  assign expire    = armed_q && (cnt_q == '0);
  assign tick_run  = expire && run;
  assign tick_halt = expire && !run;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (start) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q) begin
      if (cnt_q == '0) begin
        if (run) cnt_q <= RELOAD;
        else     armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick_run && !clr && !start) |=> !tick_run); // R2
  AST_HALT_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (tick_halt && !start) |=> !armed_q); // R3
endmodule

// File: rtl/usbh_cause_acc.sv
module usbh_cause_acc (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_all,
  input  logic       ev_ioc,
  input  logic       ev_short,
  input  logic       tick,
  input  logic       ack,
  output logic [1:0] cause_o,
  output logic       raise_o
);
  logic [1:0] pend_q;
  logic [1:0] cause_q;
  logic [1:0] ev_now;

  assign ev_now  = {ev_short, ev_ioc};
  assign raise_o = tick && (pend_q != 2'b00);
  assign cause_o = cause_q;

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      pend_q  <= '0;
      cause_q <= '0;
    end else begin
      pend_q  <= tick ? ev_now : (pend_q | ev_now);
      cause_q <= (ack ? 2'b00 : cause_q) | (tick ? pend_q : 2'b00);
    end
  end

  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ack && !clr_all) |=> $stable(cause_q)); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack && !tick) |=> (cause_q == 2'b00)); // R8
endmodule

// File: rtl/usbh_irq_gen.sv
module usbh_irq_gen
  import usbh_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cause,
  input  logic [IEN_W-1:0] ien,
  input  logic             sts_err,
  input  logic             sts_res,
  input  logic             sts_hse,
  input  logic             sts_perr,
  output logic             irq_o
);
  logic lvl;

  always_comb begin
    lvl = (cause[0] && ien[E_IOC]) ||
          (cause[1] && ien[E_SPD]) ||
          (sts_err  && ien[E_ERR]) ||
          (sts_res  && ien[E_RES]) ||
          sts_hse || sts_perr;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= lvl;
  end

  AST_IRQ_FATAL: assert property (@(posedge clk) disable iff (rst)
    (sts_hse || sts_perr) |=> irq_o); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    ((ien == '0) && !sts_hse && !sts_perr) |=> !irq_o); // R9
endmodule

// File: rtl/usbh_frame_ctl.sv
module usbh_frame_ctl
  import usbh_ctl_pkg::*;
#(
  parameter int FRAME_CYC = 12000,
  parameter int DATA_W    = 32,
  parameter int FRNUM_W   = 11,
  parameter int LIST_W    = 10,
  parameter int ALIGN_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_ioc,
  input  logic              ev_short,
  input  logic              ev_usb_err,
  input  logic              ev_host_err,
  input  logic              ev_proc_err,
  input  logic              resume_req,
  output logic              frame_tick,
  output logic [DATA_W-1:0] sched_addr,
  output logic              bus_reset,
  output logic              irq
);
  localparam int BASE_HI = DATA_W - ALIGN_W;
  localparam int PAD_W   = DATA_W - LIST_W - 2;

  logic [CMD_W-1:0]   cmd_q;
  logic               usbint_q, err_q, res_q, hse_q, perr_q, halted_q;
  logic [IEN_W-1:0]   ien_q;
  logic [FRNUM_W-1:0] frnum_q;
  logic [BASE_HI-1:0] base_q;
  logic [DATA_W-1:0]  base_full;
  logic [STS_W-1:0]   sts_word;

  logic wr_cmd, wr_sts, wr_ien, wr_frm, wr_base;
  logic hc_rst_w, start_w, stop_w, ack_w;
  logic tick_run, tick_halt, raise;
  logic [1:0] cause;

  assign wr_cmd  = reg_wr && (reg_sel == SEL_CMD);
  assign wr_sts  = reg_wr && (reg_sel == SEL_STS);
  assign wr_ien  = reg_wr && (reg_sel == SEL_IEN);
  assign wr_frm  = reg_wr && (reg_sel == SEL_FRM);
  assign wr_base = reg_wr && (reg_sel == SEL_BASE);

  assign hc_rst_w = wr_cmd && reg_wdata[C_HCRST];
  assign start_w  = wr_cmd && reg_wdata[C_RUN] && !cmd_q[C_RUN] && !hc_rst_w;
  assign stop_w   = wr_cmd && !reg_wdata[C_RUN];
  assign ack_w    = wr_sts && reg_wdata[S_INT];

  assign base_full = {base_q, {ALIGN_W{1'b0}}};
  assign sts_word  = {halted_q, perr_q, hse_q, res_q, err_q, usbint_q};

  usbh_frame_timer #(.FRAME_CYC(FRAME_CYC)) timer_i (
    .clk       (clk),
    .rst       (rst),
    .clr       (hc_rst_w),
    .start     (start_w),
    .run       (cmd_q[C_RUN]),
    .tick_run  (tick_run),
    .tick_halt (tick_halt)
  );

  usbh_cause_acc cause_i (
    .clk      (clk),
    .rst      (rst),
    .clr_all  (hc_rst_w),
    .ev_ioc   (ev_ioc),
    .ev_short (ev_short),
    .tick     (tick_run),
    .ack      (ack_w),
    .cause_o  (cause),
    .raise_o  (raise)
  );

  usbh_irq_gen irq_i (
    .clk      (clk),
    .rst      (rst),
    .cause    (cause),
    .ien      (ien_q),
    .sts_err  (err_q),
    .sts_res  (res_q),
    .sts_hse  (hse_q),
    .sts_perr (perr_q),
    .irq_o    (irq)
  );

  // command register
  always_ff @(posedge clk) begin
    if (rst || hc_rst_w) begin
      cmd_q <= '0;
    end else if (wr_cmd) begin
      cmd_q <= reg_wdata[CMD_W-1:0];
    end else if (resume_req && cmd_q[C_SUSP]) begin
      cmd_q[C_FRES] <= 1'b1;
    end
  end

  // halted flag
  always_ff @(posedge clk) begin
    if (rst || hc_rst_w)   halted_q <= 1'b1;
    else if (start_w)      halted_q <= 1'b0;
    else if (stop_w)       halted_q <= 1'b1;
    else if (tick_halt)    halted_q <= 1'b1;
  end

  // status flags: set wins over write-1-to-clear
  always_ff @(posedge clk) begin
    if (rst || hc_rst_w) begin
      usbint_q <= 1'b0;
      err_q    <= 1'b0;
      res_q    <= 1'b0;
      hse_q    <= 1'b0;
      perr_q   <= 1'b0;
    end else begin
      if (raise)                                usbint_q <= 1'b1;
      else if (ack_w)                           usbint_q <= 1'b0;
      if (ev_usb_err)                           err_q <= 1'b1;
      else if (wr_sts && reg_wdata[S_ERR])      err_q <= 1'b0;
      if (resume_req && cmd_q[C_SUSP])          res_q <= 1'b1;
      else if (wr_sts && reg_wdata[S_RES])      res_q <= 1'b0;
      if (ev_host_err)                          hse_q <= 1'b1;
      else if (wr_sts && reg_wdata[S_HSE])      hse_q <= 1'b0;
      if (ev_proc_err)                          perr_q <= 1'b1;
      else if (wr_sts && reg_wdata[S_PERR])     perr_q <= 1'b0;
    end
  end

  // enable, frame counter, base
  always_ff @(posedge clk) begin
    if (rst || hc_rst_w) begin
      ien_q   <= '0;
      frnum_q <= '0;
      base_q  <= '0;
    end else begin
      if (wr_ien) ien_q <= reg_wdata[IEN_W-1:0];
      if (tick_run)                 frnum_q <= frnum_q + 1'b1;
      else if (wr_frm && halted_q)  frnum_q <= reg_wdata[FRNUM_W-1:0];
      if (wr_base) base_q <= reg_wdata[DATA_W-1:ALIGN_W];
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_tick <= 1'b0;
      bus_reset  <= 1'b0;
      sched_addr <= '0;
      reg_rdata  <= '0;
    end else begin
      frame_tick <= tick_run;
      bus_reset  <= wr_cmd && reg_wdata[C_GRST];
      sched_addr <= base_full + {{PAD_W{1'b0}}, frnum_q[LIST_W-1:0], 2'b00};
      case (reg_sel)
        SEL_CMD:  reg_rdata <= {{(DATA_W-CMD_W){1'b0}}, cmd_q};
        SEL_STS:  reg_rdata <= {{(DATA_W-STS_W){1'b0}}, sts_word};
        SEL_IEN:  reg_rdata <= {{(DATA_W-IEN_W){1'b0}}, ien_q};
        SEL_FRM:  reg_rdata <= {{(DATA_W-FRNUM_W){1'b0}}, frnum_q};
        SEL_BASE: reg_rdata <= base_full;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  AST_START_CLEARS_HALT: assert property (@(posedge clk) disable iff (rst)
    start_w |=> !halted_q); // R2
  AST_STOP_SETS_HALT: assert property (@(posedge clk) disable iff (rst)
    stop_w |=> halted_q); // R3
  AST_FRNUM_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick_run && !hc_rst_w) |=> (frnum_q == FRNUM_W'($past(frnum_q) + 1'b1))); // R4
  AST_FRNUM_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!halted_q && !tick_run && !hc_rst_w) |=> $stable(frnum_q)); // R5
  AST_RESUME_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (resume_req && cmd_q[C_SUSP] && !wr_cmd) |=> (cmd_q[C_FRES] && res_q)); // R10
  AST_BUS_RESET_SRC: assert property (@(posedge clk) disable iff (rst)
    bus_reset |-> $past(wr_cmd && reg_wdata[C_GRST])); // R12
  AST_HCRESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    hc_rst_w |=> (halted_q && cmd_q == '0 && frnum_q == '0)); // R11
endmodule

// File: tb/usbh_frame_ctl_tb.sv
module usbh_frame_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_CYC  = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ev_ioc = 0, ev_short = 0, ev_usb_err = 0, ev_host_err = 0, ev_proc_err = 0;
  logic resume_req = 0;
  logic frame_tick, bus_reset, irq;
  logic [31:0] sched_addr;

  int n_chk = 0;
  int n_bad = 0;
  int tick_seen = 0;
  bit rd_pend = 1'b0;
  string       tag_q[$];
  logic [31:0] exp_q[$];

  usbh_frame_ctl #(.FRAME_CYC(FRAME_CYC)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_ioc(ev_ioc), .ev_short(ev_short), .ev_usb_err(ev_usb_err),
    .ev_host_err(ev_host_err), .ev_proc_err(ev_proc_err),
    .resume_req(resume_req), .frame_tick(frame_tick),
    .sched_addr(sched_addr), .bus_reset(bus_reset), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge frame_tick) tick_seen++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare registered read data against the scoreboard
  always @(posedge clk) begin
    if (rd_pend) begin
      #2;
      if (exp_q.size() > 0) chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [2:0] s, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] s, logic [31:0] e, string tag);
    @(negedge clk); reg_sel = s; tag_q.push_back(tag); exp_q.push_back(e); rd_pend = 1'b1;
    @(negedge clk); rd_pend = 1'b0;
  endtask

  task automatic wait_tick();
    @(posedge frame_tick); @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k;
    int t0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3'd0, 32'h00, "R1 cmd");
    rd(3'd1, 32'h20, "R1 sts");
    rd(3'd2, 32'h0, "R1 ien");
    rd(3'd3, 32'h0, "R1 frm");
    rd(3'd4, 32'h0, "R1 base");
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 frame_tick", {31'd0, frame_tick}, 32'd0);
    chk("R1 bus_reset", {31'd0, bus_reset}, 32'd0);

    // R6 base alignment, R5 masked write while halted
    wr(3'd4, 32'h1234_5FFF);
    rd(3'd4, 32'h1234_5000, "R6 base aligned");
    wr(3'd3, 32'h0000_FFFF);
    rd(3'd3, 32'h7FF, "R5 frm masked");
    idle(2);
    chk("R6 sched_addr", sched_addr, 32'h1234_5FFC);

    // R2 start, R4 wrap, R5 ignored while running
    tick_seen = 0;
    wr(3'd0, 32'h1);
    @(negedge clk);
    chk("R2 first tick", {31'd0, frame_tick}, 32'd1);
    wr(3'd3, 32'h5);
    rd(3'd3, 32'h0, "R4 wrap / R5 ignored");
    rd(3'd1, 32'h00, "R2 halted cleared");
    wait_tick();
    k = 0;
    do begin @(negedge clk); k++; end while (frame_tick !== 1'b1);
    chk("R2 period", k, FRAME_CYC);
    wait_tick();
    wait_tick();
    wr(3'd0, 32'h0);
    idle(2);
    rd(3'd3, (32'h7FF + tick_seen) & 32'h7FF, "R4 count");
    rd(3'd1, 32'h20, "R3 halted set");
    t0 = tick_seen;
    idle(3 * FRAME_CYC);
    chk("R3 no ticks", tick_seen, t0);

    // R7 / R9 hidden causes
    wr(3'd2, 32'h4);
    wr(3'd0, 32'h1);
    wait_tick();
    @(negedge clk) ev_ioc = 1; @(negedge clk) ev_ioc = 0;
    wait_tick(); @(negedge clk);
    chk("R9 ioc irq", {31'd0, irq}, 32'd1);
    rd(3'd1, 32'h01, "R7 usbint set");
    wr(3'd1, 32'h1); @(negedge clk);
    chk("R8 ack irq low", {31'd0, irq}, 32'd0);
    rd(3'd1, 32'h00, "R8 usbint cleared");
    wr(3'd2, 32'h8);
    wait_tick();
    @(negedge clk) ev_ioc = 1; @(negedge clk) ev_ioc = 0;
    wait_tick(); @(negedge clk);
    rd(3'd1, 32'h01, "R7 ioc latched");
    chk("R9 ioc gated by spd enable", {31'd0, irq}, 32'd0);
    wr(3'd1, 32'h1);
    wait_tick();
    @(negedge clk) ev_short = 1; @(negedge clk) ev_short = 0;
    wait_tick(); @(negedge clk);
    chk("R9 short irq", {31'd0, irq}, 32'd1);
    wr(3'd1, 32'h1);
    wait_tick(); @(negedge clk);
    rd(3'd1, 32'h00, "R7 empty frame");
    wr(3'd0, 32'h0);

    // R8 / R9 error flags
    wr(3'd2, 32'h0);
    @(negedge clk) ev_usb_err = 1; @(negedge clk) ev_usb_err = 0;
    @(negedge clk);
    chk("R9 err masked", {31'd0, irq}, 32'd0);
    rd(3'd1, 32'h22, "R8 err set");
    wr(3'd2, 32'h1); idle(2);
    chk("R9 err enabled", {31'd0, irq}, 32'd1);
    wr(3'd1, 32'h2); @(negedge clk);
    chk("R8 err w1c irq", {31'd0, irq}, 32'd0);
    rd(3'd1, 32'h20, "R8 err cleared");
    @(negedge clk) ev_host_err = 1; @(negedge clk) ev_host_err = 0;
    @(negedge clk);
    chk("R9 hse no enable", {31'd0, irq}, 32'd1);
    rd(3'd1, 32'h28, "R8 hse set");
    wr(3'd1, 32'h3F);
    rd(3'd1, 32'h20, "R8 halted not writable");
    @(negedge clk) ev_proc_err = 1; @(negedge clk) ev_proc_err = 0;
    @(negedge clk);
    chk("R9 perr no enable", {31'd0, irq}, 32'd1);
    rd(3'd1, 32'h30, "R8 perr set");
    wr(3'd1, 32'h10);
    rd(3'd1, 32'h20, "R8 perr cleared");

    // R10 resume
    @(negedge clk) resume_req = 1; @(negedge clk) resume_req = 0;
    rd(3'd0, 32'h00, "R10 ignored cmd");
    rd(3'd1, 32'h20, "R10 ignored sts");
    wr(3'd2, 32'h2);
    wr(3'd0, 32'h08);
    @(negedge clk) resume_req = 1; @(negedge clk) resume_req = 0;
    @(negedge clk);
    chk("R10 resume irq", {31'd0, irq}, 32'd1);
    rd(3'd0, 32'h18, "R10 force resume");
    rd(3'd1, 32'h24, "R10 resume detect");
    wr(3'd1, 32'h4);

    // R12 global reset pulse
    wr(3'd0, 32'h04);
    chk("R12 pulse high", {31'd0, bus_reset}, 32'd1);
    @(negedge clk);
    chk("R12 pulse one cycle", {31'd0, bus_reset}, 32'd0);
    rd(3'd0, 32'h04, "R12 cmd value");

    // R11 controller reset
    wr(3'd2, 32'hF);
    wr(3'd4, 32'hABCD_E000);
    @(negedge clk) ev_host_err = 1; @(negedge clk) ev_host_err = 0;
    wr(3'd0, 32'h1);
    wait_tick();
    wr(3'd0, 32'h2);
    rd(3'd0, 32'h00, "R11 cmd");
    rd(3'd1, 32'h20, "R11 sts");
    rd(3'd2, 32'h0, "R11 ien");
    rd(3'd3, 32'h0, "R11 frm");
    rd(3'd4, 32'h0, "R11 base");
    chk("R11 irq", {31'd0, irq}, 32'd0);
    t0 = tick_seen;
    idle(3 * FRAME_CYC);
    chk("R11 timer stopped", tick_seen, t0);
    chk("R11 sched_addr", sched_addr, 32'h0);

    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule